// File: doc/BRIEF.md
# Bitfield Extract Execution Unit

This 32-bit integer execution unit pulls a contiguous bit field out of a base operand and returns it right-justified in a result word. A control operand supplies the field's start position and length. A few bits of the 64-bit instruction word select the options: bit-reverse the base first, sign-extend the field instead of zero-filling it, and update the condition flags.

The unit is a single stage. An operation presented with `in_valid` appears on the registered outputs on the next clock edge, with `out_valid` set. The destination register index travels with the result so that a writeback stage can use it. Zero length, a start position beyond the word, and a field that runs off the top of the word each give a defined result.

Top module: `bfx_unit`

## Requirements
- R1: `out_valid` rises on the clock edge that samples `in_valid` high and is low after any edge that samples `in_valid` low. A synchronous active-high `rst` clears `out_valid` and `flags_we`.
- R2: `dest` equals `instr[7:0]` of the accepted operation. In unsigned mode (`instr[48]`=0), `result` holds base bits [start+len-1:start], where start=`ctrl[7:0]` and len=`ctrl[15:8]`. The field sits in the low bits and all bits above it are zero.
- R3: With `instr[40]`=1, the base is bit-reversed (bit k takes bit 31-k) before any other rule is applied.
- R4: A length of zero gives a result of 0 in every mode. This rule overrides all the others.
- R5: In unsigned mode, a start position of 32 or more gives 0.
- R6: In signed mode (`instr[48]`=1), every bit above the extracted field equals base bit min(start+len,32)-1.
- R7: In signed mode with start ≥ 32 and a non-zero length, every result bit equals base bit 31.
- R8: In signed mode with start+len ≥ 32, result bit 31 equals base bit 31.
- R9: When `instr[47]`=1, `flags_we` is high along with the result. `flag_z` is set exactly when the result is 0, `flag_s` equals result bit 31, and `flag_c` and `flag_o` are 0. When `instr[47]`=0, `flags_we` is low.
- R10: In unsigned mode, field bits that lie above base bit 31 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| instr | input | 64 | Instruction word: [7:0] destination, [40] reverse, [47] flag update, [48] signed |
| base | input | 32 | Base operand |
| ctrl | input | 32 | Control operand: [7:0] start position, [15:8] length |
| out_valid | output | 1 | Registered result valid |
| dest | output | 8 | Destination register index |
| result | output | 32 | Extracted field |
| flags_we | output | 1 | Flag write enable |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |
| flag_c | output | 1 | Carry flag (always written as 0) |
| flag_o | output | 1 | Overflow flag (always written as 0) |

## Verification
Directed operations cover the following cases:
- a mid-word unsigned field and a field straddling bit 31, which separate masking from truncation;
- reversed bases that have a single set bit, which show the reversal direction;
- zero-length operations with start values that would otherwise replicate, which show that the zero rule takes precedence;
- signed fields whose top bit is 0 and then 1, which separate zero-fill from sign-fill;
- starts beyond the word in both modes, which separate replication from clearing.

Flag operations produce zero, negative and positive results, plus an operation with flag update off. A long stream of back-to-back operations with random starts, lengths and modes, biased toward the boundaries, is then compared in order against an independent shift-and-mask model.

// File: rtl/bfx_pkg.sv
package bfx_pkg;

    localparam int unsigned XLEN  = 32;
    localparam int unsigned IW    = 64;
    localparam int unsigned RW    = 8;
    localparam int unsigned FW    = 8;
    localparam int unsigned SUM_W = FW + 1;

    // instruction-word option bits that decoding depends on
    localparam int unsigned REV_POS = 40;
    localparam int unsigned UPD_POS = 47;
    localparam int unsigned SGN_POS = 48;

    typedef struct packed {
        logic [RW-1:0] dest;
        logic          rev;
        logic          upd;
        logic          sgn;
        logic [FW-1:0] start;
        logic [FW-1:0] len;
    } op_t;

    typedef struct packed {
        logic z;
        logic s;
        logic c;
        logic o;
    } flags_t;

    function automatic logic [XLEN-1:0] mirror(input logic [XLEN-1:0] v);
        logic [XLEN-1:0] r;
        for (int k = 0; k < XLEN; k++) begin
            r[k] = v[XLEN-1-k];
        end
        return r;
    endfunction

endpackage

// File: rtl/bfx_decode.sv
module bfx_decode
    import bfx_pkg::*;
(
    input  logic [IW-1:0]   instr,
    input  logic [XLEN-1:0] ctrl,
    output op_t             op
);
    always_comb begin
        op.dest  = instr[RW-1:0];
        op.rev   = instr[REV_POS];
        op.upd   = instr[UPD_POS];
        op.sgn   = instr[SGN_POS];
        op.start = ctrl[FW-1:0];
        op.len   = ctrl[2*FW-1:FW];
    end
endmodule

// File: rtl/bfx_core.sv
module bfx_core
    import bfx_pkg::*;
#(
    parameter int unsigned DATA_W = XLEN
) (
    input  op_t               op,
    input  logic [DATA_W-1:0] base,
    output logic [DATA_W-1:0] res
);
    localparam int unsigned IDX_W = $clog2(DATA_W);

    logic [DATA_W-1:0] src;
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] keep;
    logic [SUM_W-1:0]  fin;
    logic              past_top;
    logic [IDX_W:0]    top;
    logic [IDX_W-1:0]  sidx;
    logic              fill;
    logic [DATA_W-1:0] staged;

    assign src     = op.rev ? mirror(src_in(base)) : base;
    assign shifted = src >> op.start;
    assign fin     = {1'b0, op.start} + {1'b0, op.len};
    assign past_top = fin >= SUM_W'(DATA_W);
    assign top     = past_top ? (IDX_W+1)'(DATA_W) : fin[IDX_W:0];
    assign sidx    = IDX_W'(top - 1'b1);
    assign fill    = op.sgn & src[sidx];

    function automatic logic [DATA_W-1:0] src_in(input logic [DATA_W-1:0] v);
        return v;
    endfunction

    // bit i is a real field bit when it is inside the length and inside the word
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            keep[i] = (SUM_W'(i) < {1'b0, op.len}) &&
                      ((SUM_W'(i) + {1'b0, op.start}) < SUM_W'(DATA_W));
        end
    end

    always_comb begin
        staged = (shifted & keep) | ({DATA_W{fill}} & ~keep);
        if (op.sgn && past_top) begin
            staged[DATA_W-1] = src[DATA_W-1];
        end
        if (op.len == '0) begin
            staged = '0;
        end
        res = staged;
    end
endmodule

// File: rtl/bfx_flags.sv
module bfx_flags
    import bfx_pkg::*;
#(
    parameter int unsigned DATA_W = XLEN
) (
    input  logic [DATA_W-1:0] res,
    output flags_t            flg
);
    always_comb begin
        flg.z = (res == '0);
        flg.s = res[DATA_W-1];
        flg.c = 1'b0;
        flg.o = 1'b0;
    end
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit
    import bfx_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [IW-1:0]   instr,
    input  logic [XLEN-1:0] base,
    input  logic [XLEN-1:0] ctrl,
    output logic            out_valid,
    output logic [RW-1:0]   dest,
    output logic [XLEN-1:0] result,
    output logic            flags_we,
    output logic            flag_z,
    output logic            flag_s,
    output logic            flag_c,
    output logic            flag_o
);
    op_t             op;
    logic [XLEN-1:0] res_c;
    flags_t          flg_c;
    flags_t          flg_q;

    bfx_decode u_dec (.instr(instr), .ctrl(ctrl), .op(op));
    bfx_core  #(.DATA_W(XLEN)) u_core (.op(op), .base(base), .res(res_c));
    bfx_flags #(.DATA_W(XLEN)) u_flg  (.res(res_c), .flg(flg_c));

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            flags_we  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            flags_we  <= in_valid & op.upd;
        end
    end

    always_ff @(posedge clk) begin
        if (in_valid) begin
            dest   <= op.dest;
            result <= res_c;
            flg_q  <= flg_c;
        end
    end

    assign flag_z = flg_q.z;
    assign flag_s = flg_q.s;
    assign flag_c = flg_q.c;
    assign flag_o = flg_q.o;

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid) // R1
        else $error("valid did not follow");
    AST_DEST_CARRIED: assert property (@(posedge clk) disable iff (rst) in_valid |=> dest == $past(instr[RW-1:0])) // R2
        else $error("dest mismatch");
    AST_ZERO_LENGTH: assert property (@(posedge clk) disable iff (rst) (in_valid && ctrl[2*FW-1:FW] == '0) |=> result == '0) // R4
        else $error("zero length not zero");
    AST_UNSIGNED_FAR: assert property (@(posedge clk) disable iff (rst) (in_valid && !instr[SGN_POS] && ctrl[FW-1:0] >= FW'(XLEN)) |=> result == '0) // R5
        else $error("far start not zero");
    AST_SIGNED_REPLICATE: assert property (@(posedge clk) disable iff (rst) (in_valid && instr[SGN_POS] && ctrl[FW-1:0] >= FW'(XLEN) && ctrl[2*FW-1:FW] != '0) |=> (result == '0 || result == '1)) // R7
        else $error("replication broken");
    AST_FLAG_ZERO: assert property (@(posedge clk) disable iff (rst) flags_we |-> (flag_z == (result == '0) && flag_s == result[XLEN-1])) // R9
        else $error("flags disagree with result");
    AST_FLAG_GATED: assert property (@(posedge clk) disable iff (rst) flags_we |-> out_valid) // R9
        else $error("flag write without result");
endmodule

// File: tb/sim_bfx_unit.sv
module sim_bfx_unit;
    typedef struct {
        logic [7:0]  dest;
        logic [31:0] res;
        logic        fwe;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] instr = '0;
    logic [31:0] base = '0;
    logic [31:0] ctrl = '0;
    logic        out_valid, flags_we, flag_z, flag_s, flag_c, flag_o;
    logic [7:0]  dest;
    logic [31:0] result;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 0;
    exp_t q[$];

    always #5 clk = ~clk;

    bfx_unit u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr), .base(base),
                 .ctrl(ctrl), .out_valid(out_valid), .dest(dest), .result(result),
                 .flags_we(flags_we), .flag_z(flag_z), .flag_s(flag_s),
                 .flag_c(flag_c), .flag_o(flag_o));

    function automatic logic [31:0] model(logic [31:0] b, bit rv, bit sg, int st, int ln);
        logic [31:0] v;
        logic [63:0] m, x;
        int e, w;
        for (int k = 0; k < 32; k++) v[k] = rv ? b[31-k] : b[k];
        if (ln == 0) return 32'd0;
        if (st >= 32) return sg ? {32{v[31]}} : 32'd0;
        e = st + ln;
        w = ((e > 32) ? 32 : e) - st;
        m = (64'd1 << w) - 64'd1;
        x = ({32'd0, v} >> st) & m;
        if (sg && x[w-1]) x = x | ~m;
        if (sg && e >= 32) x[31] = v[31];
        return x[31:0];
    endfunction

    task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic send(logic [7:0] d, bit rv, bit upd, bit sg, int st, int ln,
                        logic [31:0] b, string tag);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        instr = '0;
        instr[7:0] = d;
        instr[15:8] = 8'h5a;
        instr[40] = rv;
        instr[47] = upd;
        instr[48] = sg;
        base = b;
        ctrl = {$urandom() & 32'hffff0000} | {16'd0, 8'(ln), 8'(st)};
        e.dest = d;
        e.res = model(b, rv, sg, st, ln);
        e.fwe = upd;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor: compare each produced result with the oldest expectation
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            exp_t e;
            if (q.size() == 0) begin
                check(1'b0, "R1", "unexpected valid", 32'd1, 32'd0);
            end else begin
                e = q.pop_front();
                check(result == e.res, e.tag, "result", result, e.res);
                check(dest == e.dest, "R2", "dest", {24'd0, dest}, {24'd0, e.dest});
                check(flags_we == e.fwe, "R9", "flags_we", {31'd0, flags_we}, {31'd0, e.fwe});
                if (e.fwe) begin
                    check(flag_z == (e.res == 0) && flag_s == e.res[31] && !flag_c && !flag_o,
                          "R9", "flags zsco", {28'd0, flag_z, flag_s, flag_c, flag_o},
                          {28'd0, e.res == 0, e.res[31], 2'b00});
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0 && flags_we == 1'b0, "R1", "reset state",
              {30'd0, out_valid, flags_we}, 32'd0);

        send(8'h12, 0, 0, 0, 4, 8, 32'hdeadbeef, "R2");
        send(8'h01, 0, 0, 0, 0, 32, 32'h89abcdef, "R2");
        send(8'h02, 0, 0, 0, 28, 10, 32'hdeadbeef, "R10");
        send(8'h03, 1, 0, 0, 31, 1, 32'h00000001, "R3");
        send(8'h04, 1, 0, 0, 0, 4, 32'h80000000, "R3");
        send(8'h05, 0, 0, 1, 40, 0, 32'hffffffff, "R4");
        send(8'h06, 0, 0, 0, 3, 0, 32'hffffffff, "R4");
        send(8'h07, 0, 0, 0, 40, 5, 32'hffffffff, "R5");
        send(8'h08, 0, 0, 1, 4, 4, 32'h00000080, "R6");
        send(8'h09, 0, 0, 1, 4, 4, 32'h00000070, "R6");
        send(8'h0a, 0, 0, 1, 33, 3, 32'h80000000, "R7");
        send(8'h0b, 0, 0, 1, 33, 3, 32'h7fffffff, "R7");
        send(8'h0c, 0, 0, 1, 20, 20, 32'h80000000, "R8");
        send(8'h0d, 1, 0, 1, 16, 200, 32'h00000001, "R8");
        idle();
        check(1'b1, "R1", "gap", 32'd0, 32'd0);
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "valid low after idle", {31'd0, out_valid}, 32'd0);
        send(8'h20, 0, 1, 0, 8, 0, 32'h12345678, "R9");
        send(8'h21, 0, 1, 1, 0, 8, 32'h00000080, "R9");
        send(8'h22, 0, 1, 0, 0, 8, 32'h00000042, "R9");
        send(8'h23, 0, 0, 0, 0, 8, 32'h00000000, "R9");
        for (int n = 0; n < 300; n++) begin
            int st, ln;
            st = (n % 4 == 0) ? (28 + int'($urandom_range(0, 8))) : int'($urandom_range(0, 40));
            ln = (n % 5 == 0) ? int'($urandom_range(0, 2)) : int'($urandom_range(0, 40));
            send(8'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()), st, ln,
                 $urandom(), "R6");
        end
        idle();
        repeat (3) @(negedge clk);
        check(q.size() == 0, "R1", "all results produced", q.size(), 32'd0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule